// File: doc/BRIEF.md
# Infrared Edge-Interval Capture Receiver

This block sits behind an infrared demodulator and measures the time between transitions of its output line. The line is brought into the clock domain through a synchronizer. A programmable prescaler divides the reference clock into interval ticks, and a counter tallies ticks since the most recent transition. When a transition of the selected polarity arrives, the tally is latched into a read-only field and an interrupt is raised. Software then rebuilds the mark/space sequence from the captured intervals and the live line level.

Software reaches the block through a word-addressed register bus with a combinational read path. Reading the second control word returns the captured interval and acknowledges the interrupt. A mode field chooses between raw edge capture and hardware frame decoding. In frame-decode mode this block only stores the mode value and raises no edge interrupts. A parameter selects which of two register layouts holds the mode field.

Top module: `ir_edge_capture`

## Requirements
- R1: After reset, the rate field in word 4 (byte 0x10) bits [11:0] reads 0x13, word 7 (byte 0x1C) reads 0, word 8 (byte 0x20) reads 0, and `irq` is low.
- R2: Words 0, 1, 2, 3 and 5 are 32-bit read/write storage. Words 9 to 15 read zero after any write. The status word 6 reads zero in every bit except bit 8.
- R3: One tick lasts rate+1 clocks. A qualifying transition arriving D clocks after the previously detected transition captures floor((D-1)/(rate+1)) into word 7 bits [28:16].
- R4: Writes to word 7 leave bits [28:16] unchanged. The writable fields of word 7 are still updated by such a write.
- R5: Word 7 bits [3:2] select which transitions qualify: 1 selects both, 2 selects falling only, 3 selects rising only, and 0 selects none. A non-qualifying transition captures nothing and raises no interrupt, but it still restarts the tick count and the prescaler.
- R6: The tick count saturates at 8191 instead of wrapping.
- R7: `irq` is a sticky level that is set by a qualifying transition in raw mode and cleared by a read of word 7. If both happen in the same cycle, the set wins.
- R8: Raw mode is mode value 2. With mode value 0 (frame decode), qualifying transitions still capture the interval but never raise `irq`.
- R9: While word 7 bit 15 (enable) is 0, no counting, capture or interrupt takes place.
- R10: While word 7 bit 0 (soft reset) is 1, the prescaler, the tick count and the captured interval are held at zero.
- R11: Status word 6 bit 8 shows the input level after a two-flop synchronizer. A change on `ir_in` appears there on the second rising clock edge that follows it.
- R12: With `LEGACY_MODE`=1, the mode field is word 7 bits [8:7] and word 8 reads zero. With `LEGACY_MODE`=0, the mode field is word 8 bits [3:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rd | input | 1 | Read strobe; a read of word 7 acknowledges the interrupt |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| ir_in | input | 1 | Demodulated infrared line, asynchronous |
| irq | output | 1 | Sticky interrupt request |

## Verification
The bench builds one instance with the default widths (12-bit rate, 13-bit interval) and the newer layout, so that saturation at 8191 is reached within about nine thousand cycles at rate 0. A second instance is built with `LEGACY_MODE`=1, which makes the alternate mode-field placement and the unmapped second mode word observable. Running at rate 3 gives intervals with several ticks in which the floor rounding of partial ticks shows. The edge-select patterns alternate polarity, so every non-qualifying transition is followed by a qualifying one whose expected interval depends on the restart.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;

   typedef enum logic [1:0] {
      EDGE_SEL_NONE = 2'd0,
      EDGE_SEL_BOTH = 2'd1,
      EDGE_SEL_FALL = 2'd2,
      EDGE_SEL_RISE = 2'd3
   } edge_sel_e;

   localparam logic [3:0] MODE_FRAME = 4'd0;
   localparam logic [3:0] MODE_RAW   = 4'd2;

   // word addresses decoded by software
   localparam int unsigned WORD_CTRL0  = 4;
   localparam int unsigned WORD_STATUS = 6;
   localparam int unsigned WORD_CTRL1  = 7;
   localparam int unsigned WORD_CTRL2  = 8;

   // plain storage words: 0..3 and 5
   localparam int unsigned TIM_N = 5;

   localparam int unsigned C1_SRST_BIT  = 0;
   localparam int unsigned C1_SEL_LSB   = 2;
   localparam int unsigned C1_LMODE_LSB = 7;
   localparam int unsigned C1_EN_BIT    = 15;
   localparam int unsigned C1_IVL_LSB   = 16;
   localparam int unsigned ST_LEVEL_BIT = 8;

   localparam int unsigned RATE_RST = 19;

   function automatic logic edge_qualifies(edge_sel_e sel, logic rise, logic fall);
      case (sel)
         EDGE_SEL_BOTH: return rise | fall;
         EDGE_SEL_FALL: return fall;
         EDGE_SEL_RISE: return rise;
         default:       return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/ir_cap_sync.sv
module ir_cap_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise,
   output logic fall
);

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         prev  <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];
   assign rise  = level & ~prev;
   assign fall  = ~level & prev;

endmodule

// File: rtl/ir_cap_timer.sv
module ir_cap_timer #(
   parameter int unsigned RATE_W = 12,
   parameter int unsigned IVL_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              run,
   input  logic              edge_any,
   input  logic              capture,
   input  logic [RATE_W-1:0] rate,
   output logic [IVL_W-1:0]  cnt,
   output logic [IVL_W-1:0]  ivl
);

   localparam logic [IVL_W-1:0] CNT_TOP = '1;

   logic [RATE_W-1:0] pre;
   logic              tick;

   // ">=" keeps the divider bounded when the rate is lowered mid-count
   assign tick = (pre >= rate);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre <= '0;
         cnt <= '0;
         ivl <= '0;
      end else if (clr) begin
         pre <= '0;
         cnt <= '0;
         ivl <= '0;
      end else if (run) begin
         if (capture) ivl <= cnt;
         if (edge_any) begin
            pre <= '0;
            cnt <= '0;
         end else if (tick) begin
            pre <= '0;
            if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
         end else begin
            pre <= pre + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ir_cap_regs.sv
module ir_cap_regs
   import ir_cap_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned RATE_W      = 12,
   parameter int unsigned IVL_W       = 13,
   parameter bit          LEGACY_MODE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IVL_W-1:0]  ivl,
   input  logic              level,
   output logic [DATA_W-1:0] rdata,
   output logic [RATE_W-1:0] rate,
   output logic              en,
   output logic              srst,
   output edge_sel_e         sel,
   output logic [3:0]        mode
);

   function automatic int unsigned slot_word(int unsigned i);
      return (i < 4) ? i : 5;
   endfunction

   logic [DATA_W-1:0] tim_q [TIM_N];
   logic [DATA_W-1:0] c1_extra, c2_rd, c1_rd;
   logic              wr_c0, wr_c1, wr_c2;

   assign wr_c0 = wr && (addr == ADDR_W'(WORD_CTRL0));
   assign wr_c1 = wr && (addr == ADDR_W'(WORD_CTRL1));
   assign wr_c2 = wr && (addr == ADDR_W'(WORD_CTRL2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < TIM_N; i++) tim_q[i] <= '0;
      end else begin
         for (int i = 0; i < TIM_N; i++)
            if (wr && (addr == ADDR_W'(slot_word(i)))) tim_q[i] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate <= RATE_W'(RATE_RST);
         en   <= 1'b0;
         srst <= 1'b0;
         sel  <= EDGE_SEL_NONE;
      end else begin
         if (wr_c0) rate <= wdata[RATE_W-1:0];
         if (wr_c1) begin
            en   <= wdata[C1_EN_BIT];
            srst <= wdata[C1_SRST_BIT];
            sel  <= edge_sel_e'(wdata[C1_SEL_LSB +: 2]);
         end
      end
   end

   generate
      if (LEGACY_MODE) begin : g_mode_in_c1
         logic [1:0] lmode_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     lmode_q <= 2'd0;
            else if (wr_c1) lmode_q <= wdata[C1_LMODE_LSB +: 2];
         end
         assign mode = {2'b00, lmode_q};
         always_comb begin
            c1_extra = '0;
            c1_extra[C1_LMODE_LSB +: 2] = lmode_q;
         end
         assign c2_rd = '0;
      end else begin : g_mode_in_c2
         logic [3:0] mode_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     mode_q <= MODE_FRAME;
            else if (wr_c2) mode_q <= wdata[3:0];
         end
         assign mode     = mode_q;
         assign c1_extra = '0;
         assign c2_rd    = DATA_W'(mode_q);
      end
   endgenerate

   always_comb begin
      c1_rd = c1_extra;
      c1_rd[C1_SRST_BIT]           = srst;
      c1_rd[C1_SEL_LSB +: 2]       = sel;
      c1_rd[C1_EN_BIT]             = en;
      c1_rd[C1_IVL_LSB +: IVL_W]   = ivl;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < TIM_N; i++)
         if (addr == ADDR_W'(slot_word(i))) rdata = tim_q[i];
      if (addr == ADDR_W'(WORD_CTRL0))       rdata = DATA_W'(rate);
      else if (addr == ADDR_W'(WORD_STATUS)) rdata[ST_LEVEL_BIT] = level;
      else if (addr == ADDR_W'(WORD_CTRL1))  rdata = c1_rd;
      else if (addr == ADDR_W'(WORD_CTRL2))  rdata = c2_rd;
   end

endmodule

// File: rtl/ir_edge_capture.sv
module ir_edge_capture
   import ir_cap_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned RATE_W      = 12,
   parameter int unsigned IVL_W       = 13,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          LEGACY_MODE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ir_in,
   output logic              irq
);

   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (ADDR_W >= 4) else $error("ADDR_W too small for the register map");
      assert (C1_IVL_LSB + IVL_W <= DATA_W) else $error("interval field exceeds DATA_W");
      assert (RATE_W >= 5 && RATE_W <= DATA_W) else $error("RATE_W out of range");
   end

   logic              level, rise, fall, edge_any;
   logic              en, srst, run, cap_evt, irq_set, rd_c1;
   logic [RATE_W-1:0] rate;
   logic [3:0]        mode;
   edge_sel_e         sel;
   logic [IVL_W-1:0]  cnt, ivl;

   ir_cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ir_in),
      .level (level),
      .rise  (rise),
      .fall  (fall)
   );

   assign edge_any = rise | fall;
   assign run      = en & ~srst;
   assign cap_evt  = run & edge_qualifies(sel, rise, fall);
   assign irq_set  = cap_evt & (mode == MODE_RAW);
   assign rd_c1    = bus_rd && (bus_addr == ADDR_W'(WORD_CTRL1));

   ir_cap_timer #(.RATE_W(RATE_W), .IVL_W(IVL_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (srst),
      .run      (run),
      .edge_any (edge_any),
      .capture  (cap_evt),
      .rate     (rate),
      .cnt      (cnt),
      .ivl      (ivl)
   );

   ir_cap_regs #(
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .RATE_W      (RATE_W),
      .IVL_W       (IVL_W),
      .LEGACY_MODE (LEGACY_MODE)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (bus_addr),
      .wr    (bus_wr),
      .wdata (bus_wdata),
      .ivl   (ivl),
      .level (level),
      .rdata (bus_rdata),
      .rate  (rate),
      .en    (en),
      .srst  (srst),
      .sel   (sel),
      .mode  (mode)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq <= 1'b0;
      else if (irq_set) irq <= 1'b1;
      else if (rd_c1)   irq <= 1'b0;
   end

endmodule

// File: rtl/ir_cap_chk.sv
module ir_cap_chk
   import ir_cap_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned IVL_W  = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              irq,
   input logic              en,
   input logic              srst,
   input logic              edge_any,
   input logic              irq_set,
   input logic [3:0]        mode,
   input logic [IVL_W-1:0]  cnt,
   input logic [IVL_W-1:0]  ivl
);

   localparam logic [IVL_W-1:0] CNT_TOP = '1;

   logic rd_ack;
   assign rd_ack = bus_rd && (bus_addr == ADDR_W'(WORD_CTRL1));

   a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !rd_ack) |=> irq);

   a_r7_irq_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ack && !irq_set) |=> !irq);

   a_r8_frame_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && mode != MODE_RAW) |=> !irq);

   a_r9_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !srst) |=> $stable(ivl));

   a_r9_disabled_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !irq) |=> !irq);

   a_r10_srst_zero: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (ivl == '0 && cnt == '0));

   a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !srst && cnt == CNT_TOP && !edge_any) |=> cnt == CNT_TOP);

endmodule

bind ir_edge_capture ir_cap_chk #(.ADDR_W(ADDR_W), .IVL_W(IVL_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_rd   (bus_rd),
   .irq      (irq),
   .en       (en),
   .srst     (srst),
   .edge_any (edge_any),
   .irq_set  (irq_set),
   .mode     (mode),
   .cnt      (cnt),
   .ivl      (ivl)
);

// File: tb/tb_ir_edge_capture.sv
module tb_ir_edge_capture;
   import ir_cap_pkg::*;

   localparam int unsigned DW = 32;
   localparam int unsigned AW = 4;
   localparam int IVL_TOP = 8191;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          wr = 1'b0, rd = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          ir_in = 1'b0;
   logic          irq;

   logic [AW-1:0] l_addr = '0;
   logic          l_wr = 1'b0, l_rd = 1'b0;
   logic [DW-1:0] l_wdata = '0;
   logic [DW-1:0] l_rdata;
   logic          l_in = 1'b0;
   logic          l_irq;

   ir_edge_capture #(.LEGACY_MODE(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
      .bus_wdata(wdata), .bus_rdata(rdata), .ir_in(ir_in), .irq(irq)
   );

   ir_edge_capture #(.LEGACY_MODE(1'b1)) dut_leg (
      .clk(clk), .rst_n(rst_n), .bus_addr(l_addr), .bus_wr(l_wr), .bus_rd(l_rd),
      .bus_wdata(l_wdata), .bus_rdata(l_rdata), .ir_in(l_in), .irq(l_irq)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    ivl;
      bit    irq;
      bit    chk;
      string req;
   } exp_t;

   exp_t      sb[$];
   int        last_cap = 0;
   int        last_edge = 0;
   int        cur_rate = 19;
   edge_sel_e cur_sel = EDGE_SEL_NONE;
   bit        cur_raw = 1'b0;

   task automatic check(string what, longint act, longint exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic bus_write(int a, logic [DW-1:0] d);
      @(negedge clk);
      addr = AW'(a); wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_read(int a, output logic [DW-1:0] d);
      @(negedge clk);
      addr = AW'(a); rd = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic l_write(int a, logic [DW-1:0] d);
      @(negedge clk);
      l_addr = AW'(a); l_wdata = d; l_wr = 1'b1;
      @(negedge clk);
      l_wr = 1'b0;
   endtask

   task automatic l_read(int a, output logic [DW-1:0] d);
      @(negedge clk);
      l_addr = AW'(a); l_rd = 1'b1;
      #1 d = l_rdata;
      @(negedge clk);
      l_rd = 1'b0;
   endtask

   function automatic logic [DW-1:0] c1_word(bit en, edge_sel_e s, bit sr);
      return (DW'(en) << C1_EN_BIT) | (DW'(s) << C1_SEL_LSB) | DW'(sr);
   endfunction

   task automatic set_ctrl1(bit en, edge_sel_e s, bit sr);
      bus_write(WORD_CTRL1, c1_word(en, s, sr));
      cur_sel = s;
   endtask

   // driver: toggles the line, predicts the result, hands it to the monitor
   task automatic send_edge(string req, bit chk);
      exp_t e;
      bit   nl, qual;
      int   gap, q;
      @(negedge clk);
      nl = ~ir_in;
      ir_in = nl;
      gap = cyc - last_edge;
      last_edge = cyc;
      qual = (cur_sel == EDGE_SEL_BOTH) || (cur_sel == EDGE_SEL_FALL && !nl) ||
             (cur_sel == EDGE_SEL_RISE && nl);
      e.req = req;
      e.chk = chk;
      e.irq = qual && cur_raw;
      if (qual) begin
         q = (gap - 1) / (cur_rate + 1);
         e.ivl = (q > IVL_TOP) ? IVL_TOP : q;
      end else begin
         e.ivl = last_cap;
      end
      repeat (4) @(negedge clk);
      sb.push_back(e);
      wait (sb.size() == 0);
   endtask

   task automatic edge_after(int d, string req);
      while (cyc + 1 < last_edge + d) @(negedge clk);
      send_edge(req, 1'b1);
   endtask

   // monitor: pops predictions and compares against the port-visible state
   initial begin : monitor
      exp_t          e;
      logic [DW-1:0] v;
      forever begin
         wait (sb.size() != 0);
         e = sb[0];
         check({e.req, " irq level (R7 sticky)"}, irq, e.irq);
         bus_read(WORD_CTRL1, v);
         check("R7 irq cleared by control read", irq, 0);
         if (e.chk) begin
            check({e.req, " captured interval"}, v[C1_IVL_LSB +: 13], e.ivl);
            last_cap = e.ivl;
         end else begin
            last_cap = int'(v[C1_IVL_LSB +: 13]);
         end
         void'(sb.pop_front());
      end
   end

   task automatic wrap_up;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      wrap_up();
   end

   initial begin : main
      logic [DW-1:0] v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_read(WORD_CTRL0, v);  check("R1 rate reset", v, 32'h13);
      bus_read(WORD_CTRL1, v);  check("R1 control word reset", v, 0);
      bus_read(WORD_CTRL2, v);  check("R1 mode reset", v, 0);
      check("R1 irq reset", irq, 0);

      // R2 storage and unmapped words
      for (int i = 0; i < 6; i++)
         if (i != 4) bus_write(i, 32'hA500_0000 | (i * 32'h111));
      for (int i = 0; i < 6; i++)
         if (i != 4) begin
            bus_read(i, v);
            check("R2 timing storage readback", v, 32'hA500_0000 | (i * 32'h111));
         end
      bus_write(9, '1);  bus_write(15, '1);
      bus_read(9, v);    check("R2 unmapped word 9", v, 0);
      bus_read(15, v);   check("R2 unmapped word 15", v, 0);
      bus_read(WORD_STATUS, v); check("R2 status other bits", v, 0);

      // R11 synchronizer latency
      @(negedge clk);
      addr = AW'(WORD_STATUS);
      ir_in = 1'b1;
      @(negedge clk); check("R11 level after one edge", rdata[ST_LEVEL_BIT], 0);
      @(negedge clk); check("R11 level after two edges", rdata[ST_LEVEL_BIT], 1);
      @(negedge clk);
      ir_in = 1'b0;
      repeat (4) @(negedge clk);

      // R3 basic interval measurement, rate 3, both edges, raw mode
      bus_write(WORD_CTRL0, 3);            cur_rate = 3;
      bus_write(WORD_CTRL2, DW'(MODE_RAW)); cur_raw = 1'b1;
      set_ctrl1(1'b1, EDGE_SEL_BOTH, 1'b0);
      send_edge("prime", 1'b0);
      edge_after(41, "R3 gap 41");
      edge_after(17, "R3 gap 17");
      edge_after(20, "R3 gap 20");
      edge_after(22, "R3 gap 22");

      // R4 read-only interval field
      bus_write(WORD_CTRL1, c1_word(1'b1, EDGE_SEL_BOTH, 1'b0) | 32'h1FFF_0000);
      bus_read(WORD_CTRL1, v);
      check("R4 interval field unchanged by write", v[C1_IVL_LSB +: 13], last_cap);
      check("R4 enable still written", v[C1_EN_BIT], 1);

      // R5 edge selection
      set_ctrl1(1'b1, EDGE_SEL_FALL, 1'b0);
      edge_after(30, "R5 falling only a");
      edge_after(25, "R5 falling only b");
      edge_after(33, "R5 falling only c");
      edge_after(27, "R5 falling only d");
      set_ctrl1(1'b1, EDGE_SEL_RISE, 1'b0);
      edge_after(30, "R5 rising only a");
      edge_after(25, "R5 rising only b");
      edge_after(33, "R5 rising only c");
      edge_after(27, "R5 rising only d");
      set_ctrl1(1'b1, EDGE_SEL_NONE, 1'b0);
      edge_after(20, "R5 select none a");
      edge_after(20, "R5 select none b");
      set_ctrl1(1'b1, EDGE_SEL_BOTH, 1'b0);
      edge_after(29, "R5 restart by ignored edge");

      // R8 frame-decode mode
      bus_write(WORD_CTRL2, DW'(MODE_FRAME)); cur_raw = 1'b0;
      edge_after(24, "R8 frame mode a");
      edge_after(36, "R8 frame mode b");
      bus_write(WORD_CTRL2, DW'(MODE_RAW));   cur_raw = 1'b1;

      // R6 saturation at rate 0
      bus_write(WORD_CTRL0, 0); cur_rate = 0;
      send_edge("prime", 1'b0);
      edge_after(9000, "R6 saturated interval");
      edge_after(100, "R6 below limit");

      // R9 disabled
      set_ctrl1(1'b0, EDGE_SEL_BOTH, 1'b0);
      @(negedge clk); ir_in = ~ir_in;
      repeat (8) @(negedge clk);
      check("R9 no irq while disabled", irq, 0);
      bus_read(WORD_CTRL1, v);
      check("R9 no capture while disabled", v[C1_IVL_LSB +: 13], last_cap);
      set_ctrl1(1'b1, EDGE_SEL_BOTH, 1'b0);
      send_edge("prime", 1'b0);

      // R10 soft reset
      set_ctrl1(1'b1, EDGE_SEL_BOTH, 1'b1);
      bus_read(WORD_CTRL1, v);
      check("R10 interval cleared by soft reset", v[C1_IVL_LSB +: 13], 0);
      @(negedge clk); ir_in = ~ir_in;
      repeat (8) @(negedge clk);
      check("R10 no irq in soft reset", irq, 0);
      bus_read(WORD_CTRL1, v);
      check("R10 interval held at zero", v[C1_IVL_LSB +: 13], 0);
      set_ctrl1(1'b1, EDGE_SEL_BOTH, 1'b0);
      send_edge("prime", 1'b0);
      edge_after(41, "R3 after soft reset release");

      // R12 legacy mode-field placement
      l_write(WORD_CTRL1, c1_word(1'b1, EDGE_SEL_BOTH, 1'b0) | (32'd2 << C1_LMODE_LSB));
      l_read(WORD_CTRL1, v);
      check("R12 legacy mode field", v[C1_LMODE_LSB +: 2], 2);
      l_write(WORD_CTRL2, 32'd2);
      l_read(WORD_CTRL2, v);
      check("R12 legacy word 8 reads zero", v, 0);
      @(negedge clk); l_in = 1'b1;
      repeat (5) @(negedge clk);
      check("R12 legacy raw irq", l_irq, 1);
      l_write(WORD_CTRL1, c1_word(1'b1, EDGE_SEL_BOTH, 1'b0));
      l_read(WORD_CTRL1, v);
      check("R12 legacy irq acknowledged", l_irq, 0);
      @(negedge clk); l_in = 1'b0;
      repeat (5) @(negedge clk);
      check("R12 legacy frame mode no irq", l_irq, 0);

      wrap_up();
   end

endmodule